// File: doc/BRIEF.md
# Non-Blocking Character I/O Port

This block is the character input/output port of a small word-oriented processor. It holds the keystrokes arriving from a keyboard in a small receive buffer, and it passes characters from the processor to a text terminal. The processor's input instruction asserts the read strobe and takes a 16-bit word back in the same cycle. The read never stalls. When no key is waiting, the port says so in-band by returning the value 128.

The processor's output instruction asserts the write strobe with a register value. The port keeps only the 7-bit character field of that value and presents it to the terminal with a one-cycle strobe. The receive buffer is updated on the falling clock edge, and the terminal side on the rising edge. An asynchronous reset empties the buffer and silences the terminal side.

Top module: `kbtty_port`

## Requirements
- R1: A read never waits. `rd_data` is valid in every cycle, including cycles in which the buffer is empty.
- R2: Bits 15 to 8 of `rd_data` are always zero.
- R3: When at least one character is buffered, `rd_data` has bit 7 equal to 0 and carries the oldest buffered character in bits 6 to 0. Characters are returned in arrival order.
- R4: When the buffer is empty, `rd_data` equals 128: bit 7 is 1 and bits 6 to 0 are 0.
- R5: A write places bits 6 to 0 of `wr_data` on `tty_char`. Bits 15 to 7 of `wr_data` have no effect.
- R6: `tty_strobe` is high for exactly the rising-edge cycle that follows a rising edge at which `wr_en` was high, and it is low at all other times.
- R7: A character presented with `kb_valid` is captured on the falling clock edge, and it appears on `rd_data` right after that edge.
- R8: On the falling edge, a read of a non-empty buffer removes the character it returned. A read of an empty buffer leaves the buffer unchanged.
- R9: The buffer holds 8 characters. A character that arrives while the buffer is full is dropped. This applies even when a read removes an entry on the same edge, because fullness is judged before that edge.
- R10: Raising `rst` empties the buffer at once, so `rd_data` reads 128. It also clears `tty_char` and `tty_strobe` at once, without waiting for a clock edge.
- R11: When the buffer is neither empty nor full, a read and an arriving character on the same falling edge both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The terminal side uses the rising edge and the buffer uses the falling edge |
| rst | input | 1 | Asynchronous reset, active high |
| rd_en | input | 1 | Input-instruction strobe; removes the returned character on the falling edge |
| wr_en | input | 1 | Output-instruction strobe |
| wr_data | input | 16 | Source register value for the output instruction |
| kb_valid | input | 1 | A keyboard character is present this cycle |
| kb_char | input | 7 | Keyboard character code |
| rd_data | output | 16 | Status/data word for the destination register |
| tty_char | output | 7 | Character sent to the terminal |
| tty_strobe | output | 1 | Terminal write pulse, one cycle |

## Verification
The bench reads an empty buffer and then checks it again. A design that stalls, or that removes a phantom entry, returns something other than 128 or corrupts the entries that follow. The bench also fills the buffer past eight entries and then reads it while another key arrives. A design that keeps a ninth character, or that treats a same-edge read as making room, returns an extra character when the buffer is drained.

Characters are written with their high bits set, so a port that passes bit 7 or above to the terminal shows a wrong character. A read and a key arrival are made to coincide on a partly filled buffer, and reset is raised in the middle of a cycle. These show a design that loses one of the two operations, or that waits for a clock edge before clearing.

// File: rtl/kbtty_pkg.sv
package kbtty_pkg;
   // Default geometry of the character port
   localparam int KB_CHAR_W = 7;
   localparam int KB_WORD_W = 16;
   localparam int KB_DEPTH  = 8;
endpackage

// File: rtl/kbtty_fifo.sv
module kbtty_fifo #(
   parameter int CHAR_W = 7,
   parameter int DEPTH  = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     push,
   input  logic [CHAR_W-1:0]        push_data,
   input  logic                     pop,
   output logic [CHAR_W-1:0]        head,
   output logic                     empty,
   output logic                     full,
   output logic [$clog2(DEPTH):0]   fill
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic              do_push;
   logic              do_pop;
   logic [CHAR_W-1:0] slots [DEPTH];

   assign empty   = (fill == '0);
   assign full    = (fill == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         logic [CHAR_W-1:0] q;
         always_ff @(negedge clk or posedge rst) begin
            if (rst)
               q <= '0;
            else if (do_push && wr_ptr == AW'(i))
               q <= push_data;
         end
         assign slots[i] = q;
      end
   endgenerate

   assign head = slots[rd_ptr];

   always_ff @(negedge clk or posedge rst) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/kbtty_fmt.sv
module kbtty_fmt #(
   parameter int CHAR_W = 7,
   parameter int WORD_W = 16
) (
   input  logic              empty,
   input  logic [CHAR_W-1:0] head,
   output logic [WORD_W-1:0] word
);
   always_comb begin
      word         = '0;
      word[CHAR_W] = empty;
      if (!empty)
         word[CHAR_W-1:0] = head;
   end
endmodule

// File: rtl/kbtty_tty.sv
module kbtty_tty #(
   parameter int CHAR_W = 7,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [CHAR_W-1:0] tty_char,
   output logic              tty_strobe
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         tty_char   <= '0;
         tty_strobe <= 1'b0;
      end else begin
         tty_strobe <= wr_en;
         if (wr_en)
            tty_char <= wr_data[CHAR_W-1:0];
      end
   end
endmodule

// File: rtl/kbtty_port.sv
module kbtty_port #(
   parameter int CHAR_W = kbtty_pkg::KB_CHAR_W,
   parameter int WORD_W = kbtty_pkg::KB_WORD_W,
   parameter int DEPTH  = kbtty_pkg::KB_DEPTH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [15:0]       wr_data,
   input  logic              kb_valid,
   input  logic [6:0]        kb_char,
   output logic [15:0]       rd_data,
   output logic [6:0]        tty_char,
   output logic              tty_strobe
);
   localparam int FW = $clog2(DEPTH) + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("kbtty_port: DEPTH must be a power of two of at least 2");
      end
      if (WORD_W < CHAR_W + 1) begin : g_bad_word
         $error("kbtty_port: WORD_W must leave room for the status bit");
      end
      if (CHAR_W != 7 || WORD_W != 16) begin : g_bad_pins
         $error("kbtty_port: port widths are fixed at 7-bit characters and 16-bit words");
      end
   endgenerate

   logic [CHAR_W-1:0] kb_head;
   logic              kb_empty;
   logic              kb_full;
   logic [FW-1:0]     fill;

   kbtty_fifo #(.CHAR_W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (kb_valid),
      .push_data (kb_char),
      .pop       (rd_en),
      .head      (kb_head),
      .empty     (kb_empty),
      .full      (kb_full),
      .fill      (fill)
   );

   kbtty_fmt #(.CHAR_W(CHAR_W), .WORD_W(WORD_W)) u_fmt (
      .empty (kb_empty),
      .head  (kb_head),
      .word  (rd_data)
   );

   kbtty_tty #(.CHAR_W(CHAR_W), .WORD_W(WORD_W)) u_tty (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .tty_char   (tty_char),
      .tty_strobe (tty_strobe)
   );
endmodule

// File: rtl/kbtty_port_chk.sv
module kbtty_port_chk #(
   parameter int CHAR_W = 7,
   parameter int WORD_W = 16,
   parameter int DEPTH  = 8
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    rd_en,
   input logic                    wr_en,
   input logic [WORD_W-1:0]       wr_data,
   input logic                    kb_valid,
   input logic [WORD_W-1:0]       rd_data,
   input logic [CHAR_W-1:0]       tty_char,
   input logic                    tty_strobe,
   input logic                    empty,
   input logic [$clog2(DEPTH):0]  fill
);
   localparam int FW = $clog2(DEPTH) + 1;

   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
      rd_data[WORD_W-1:CHAR_W+1] == '0);

   assert_empty_word_R4: assert property (@(posedge clk) disable iff (rst)
      empty |-> rd_data == WORD_W'(1 << CHAR_W));

   assert_char_word_R3: assert property (@(posedge clk) disable iff (rst)
      !empty |-> !rd_data[CHAR_W]);

   assert_tty_char_R5: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> tty_strobe && tty_char == $past(wr_data[CHAR_W-1:0]));

   assert_tty_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> !tty_strobe);

   assert_fill_cap_R9: assert property (@(negedge clk) disable iff (rst)
      fill <= FW'(DEPTH));

   assert_drop_full_R9: assert property (@(negedge clk) disable iff (rst)
      (fill == FW'(DEPTH) && kb_valid && !rd_en) |=> fill == FW'(DEPTH));

   assert_empty_read_R8: assert property (@(negedge clk) disable iff (rst)
      (rd_en && empty && !kb_valid) |=> fill == '0);
endmodule

bind kbtty_port kbtty_port_chk #(.CHAR_W(CHAR_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .rd_en      (rd_en),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .kb_valid   (kb_valid),
   .rd_data    (rd_data),
   .tty_char   (tty_char),
   .tty_strobe (tty_strobe),
   .empty      (kb_empty),
   .fill       (fill)
);

// File: tb/kbtty_port_test.sv
module kbtty_port_test;
   localparam int CLK_PERIOD = 10;
   localparam int KB_CAP     = 8;

   logic        clk = 1'b0;
   logic        rst;
   logic        rd_en, wr_en, kb_valid;
   logic [15:0] wr_data;
   logic [6:0]  kb_char;
   logic [15:0] rd_data;
   logic [6:0]  tty_char;
   logic        tty_strobe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [6:0] tty_q [$];
   logic [6:0] kb_q  [$];

   kbtty_port uut (
      .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
      .kb_valid(kb_valid), .kb_char(kb_char), .rd_data(rd_data),
      .tty_char(tty_char), .tty_strobe(tty_strobe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] expect_word();
      if (kb_q.size() == 0) return 16'h0080;
      return {9'b0, kb_q[0]};
   endfunction

   // Driver: one cycle of stimulus, with the models updated for its edges
   task automatic drive(bit rd, bit wr, logic [15:0] wd, bit kv, logic [6:0] kc, string tag);
      int pre;
      @(posedge clk);
      #2;
      if (rd) check(tag, rd_data, expect_word());
      rd_en = rd; wr_en = wr; wr_data = wd; kb_valid = kv; kb_char = kc;
      pre = kb_q.size();
      if (rd && pre > 0) void'(kb_q.pop_front());
      if (kv && pre < KB_CAP) kb_q.push_back(kc);
      if (wr) tty_q.push_back(wd[6:0]);
   endtask

   task automatic idle();
      drive(0, 0, 16'h0, 0, 7'h0, "");
   endtask

   task automatic peek(string tag);
      @(posedge clk);
      #2;
      rd_en = 0; wr_en = 0; kb_valid = 0;
      check(tag, rd_data, expect_word());
   endtask

   // Monitor: every terminal strobe is matched against the scoreboard
   always @(posedge clk) begin
      #1;
      if (!rst && tty_strobe) begin
         checks++;
         if (tty_q.size() == 0) begin
            errors++;
            $display("FAIL R6: actual strobe 1 expected 0 (no write pending)");
         end else begin
            logic [6:0] e;
            e = tty_q.pop_front();
            if (tty_char !== e) begin
               errors++;
               $display("FAIL R5: actual 0x%02h expected 0x%02h", tty_char, e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1; rd_en = 0; wr_en = 0; wr_data = 0; kb_valid = 0; kb_char = 0;
      #1;
      check("R10 reset word", rd_data, 16'h0080);
      check("R10 reset strobe", {15'b0, tty_strobe}, 16'h0);
      check("R10 reset char", {9'b0, tty_char}, 16'h0);
      repeat (3) @(posedge clk);
      #2 rst = 0;

      // R1 R4: an empty read returns at once; R8: it changes nothing
      drive(1, 0, 0, 0, 0, "R1 R4 empty read");
      idle();
      peek("R8 after empty read");

      // R7: a key appears right after the falling edge
      drive(0, 0, 0, 1, 7'h41, "");
      @(negedge clk);
      #1;
      check("R7 capture on falling edge", rd_data, 16'h0041);
      drive(0, 0, 0, 1, 7'h48, "");
      drive(0, 0, 0, 1, 7'h7F, "");
      idle();
      peek("R3 R2 oldest first");
      drive(1, 0, 0, 0, 0, "R3 first read");
      drive(1, 0, 0, 0, 0, "R3 second read");
      // R11: a read and an arrival on the same edge
      drive(1, 0, 0, 1, 7'h7A, "R11 read with arrival");
      peek("R11 arrival kept");
      drive(1, 0, 0, 0, 0, "R8 pop last");
      peek("R4 empty again");

      // R9: overfill, then read while full as another key arrives
      for (int i = 0; i < 10; i++) drive(0, 0, 0, 1, 7'(7'h30 + i), "");
      idle();
      peek("R9 full head");
      drive(1, 0, 0, 1, 7'h23, "R9 read at full");
      for (int i = 0; i < 8; i++) drive(1, 0, 0, 0, 0, "R9 drain");
      peek("R9 drained");

      // R5 R6: terminal writes with high bits set, back to back
      drive(0, 1, 16'hFFC1, 0, 0, "");
      drive(0, 1, 16'h008A, 0, 0, "");
      drive(0, 1, 16'h7F20, 0, 0, "");
      idle();
      idle();
      @(posedge clk);
      #1;
      check("R6 quiet after writes", {15'b0, tty_strobe}, 16'h0);

      // R10: reset in the middle of a cycle with buffer and terminal busy
      drive(0, 0, 0, 1, 7'h51, "");
      drive(0, 0, 0, 1, 7'h52, "");
      drive(0, 1, 16'h0051, 0, 0, "");
      @(posedge clk);
      #3;
      wr_en = 0;
      rst = 1;
      #1;
      check("R10 async buffer clear", rd_data, 16'h0080);
      check("R10 async strobe clear", {15'b0, tty_strobe}, 16'h0);
      check("R10 async char clear", {9'b0, tty_char}, 16'h0);
      kb_q.delete();
      @(posedge clk);
      #2 rst = 0;
      peek("R10 stays empty");
      idle();

      checks++;
      if (tty_q.size() != 0) begin
         errors++;
         $display("FAIL R6: actual %0d pending writes expected 0", tty_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule